// File: doc/BRIEF.md
# Bus-master storage DMA control register block

This block is the host-visible control core of a single-channel bus-master DMA engine for a storage drive. Software programs the transfer direction, places the base address of the descriptor table and arms the transfer by setting a start flag. It does this only after the command has gone to the drive. When the transfer is over, software clears start and then reads the status flags to learn how the transfer ended.

A datapath outside this block moves the data and fetches the descriptors. It tells this block about a finished transfer, a failed transfer and a raised interrupt through single-cycle event inputs. The block keeps sticky error and interrupt flags, which software clears by writing a one. It also keeps two per-drive capability flags that hold whatever software writes to them. The interrupt flag drives the host interrupt line as a level. When start is cleared, the block gives one-cycle pulses that grade the transfer as good or bad.

Writes use a word index on `wr_addr`. Reads are combinational from `rd_addr`. The index map is: 0 is the command register, 1 is the status register, 2 is the descriptor table base, and 3 reads as zero and ignores writes.

Top module: `bmdma_ctrl`

## Requirements
- R1: Status bit 5 (drive 0) and bit 6 (drive 1) are capability flags. A write to index 1 loads both from the written data, and they keep their value until the next such write.
- R2: Status bit 1 (error) and bit 2 (interrupt) clear when index 1 is written with a 1 in that position. Writing 0 leaves them unchanged. A datapath event that sets a flag in the same cycle as a clearing write wins, so the flag stays 1.
- R3: Status bit 0 (active) ignores writes. It becomes 1 on the write that takes start from 0 to 1. It becomes 0 on `dp_done`, on `dp_error`, or on the write that clears start. When start rises in the same cycle as `dp_done` or `dp_error`, the rise wins.
- R4: Command bit 0 is start and bit 3 is direction, where 1 means data goes into memory. Both are loaded by a write to index 0, other command bits read as 0, and `run` and `dir_to_mem` show the two bits.
- R5: `dp_error` sets the error flag. `dp_done` or `dp_irq` sets the interrupt flag. Events are taken whether or not a transfer is active.
- R6: A write that takes start from 1 to 0 produces exactly one pulse in the next cycle. The pulse is on `good_done` when, before that write, active=0, error=0 and interrupt=1. Otherwise the pulse is on `bad_done`.
- R7: Index 2 holds a 32-bit table base whose bits 1:0 always read 0. A write to it while start is 1 is ignored.
- R8: `host_irq` equals the interrupt flag.
- R9: After reset, all registers, flags and outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register index of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Register index to read |
| rd_data | output | 32 | Read data of the indexed register |
| dp_done | input | 1 | Datapath event: transfer finished |
| dp_error | input | 1 | Datapath event: transfer failed |
| dp_irq | input | 1 | Datapath event: drive raised an interrupt |
| run | output | 1 | Start flag to the datapath |
| dir_to_mem | output | 1 | Direction to the datapath, 1 = into memory |
| table_base | output | 32 | Descriptor table base address |
| host_irq | output | 1 | Interrupt level to the host |
| good_done | output | 1 | One-cycle pulse: stopped transfer graded good |
| bad_done | output | 1 | One-cycle pulse: stopped transfer graded bad |

## Verification
Two functions can fall in the same cycle here: a software write-one-to-clear of error or interrupt, and a datapath event that sets the same flag. The same applies to a start rise and a done or error event that would clear active. Directed steps put a clearing write to index 1 in the same cycle as `dp_error` and `dp_irq`, and put the start write in the same cycle as `dp_done`. The random phase then mixes writes and events freely so that such collisions recur. Each outcome is judged against a bench model in which setting beats clearing and a start rise beats the clearing events.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 2;

  localparam logic [IDX_W-1:0] IDX_CMD  = 2'd0;
  localparam logic [IDX_W-1:0] IDX_STAT = 2'd1;
  localparam logic [IDX_W-1:0] IDX_PTR  = 2'd2;

  // command bit positions
  localparam int CMD_RUN = 0;
  localparam int CMD_DIR = 3;
  // status bit positions
  localparam int ST_ACT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_INT  = 2;
  localparam int ST_CAP0 = 5;
  localparam int ST_CAP1 = 6;
  // descriptor pointer alignment
  localparam int PTR_LSB = 2;

  // good outcome: idle, no fault, interrupt seen
  function automatic logic outcome_good(input logic act, input logic err, input logic intr);
    return !act && !err && intr;
  endfunction
endpackage

// File: rtl/bmdma_cmd_reg.sv
module bmdma_cmd_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_run,
  input  logic wr_dir,
  output logic run,
  output logic dir,
  output logic run_rise,
  output logic run_fall
);
  assign run_rise = wr && wr_run && !run;
  assign run_fall = wr && !wr_run && run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      dir <= 1'b0;
    end else if (wr) begin
      run <= wr_run;
      dir <= wr_dir;
    end
  end
endmodule

// File: rtl/bmdma_status_reg.sv
module bmdma_status_reg
  import bmdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       w1c_err,
  input  logic       w1c_int,
  input  logic [1:0] wr_cap,
  input  logic       run,
  input  logic       run_rise,
  input  logic       run_fall,
  input  logic       ev_done,
  input  logic       ev_err,
  input  logic       ev_irq,
  output logic       active,
  output logic       err,
  output logic       intr,
  output logic [1:0] cap,
  output logic       good_done,
  output logic       bad_done
);
  logic set_err, set_int, clr_act, judged_good;

  assign set_err     = ev_err;
  assign set_int     = ev_done || ev_irq;
  assign clr_act     = ev_done || ev_err || run_fall;
  assign judged_good = outcome_good(active, err, intr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      err       <= 1'b0;
      intr      <= 1'b0;
      cap       <= '0;
      good_done <= 1'b0;
      bad_done  <= 1'b0;
    end else begin
      if (run_rise)     active <= 1'b1;
      else if (clr_act) active <= 1'b0;
      err       <= set_err || (err  && !(wr && w1c_err));
      intr      <= set_int || (intr && !(wr && w1c_int));
      if (wr) cap <= wr_cap;
      good_done <= run_fall && judged_good;
      bad_done  <= run_fall && !judged_good;
    end
  end

  AST_ACTIVE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> run); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> err); // R2
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cap)); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (good_done || bad_done) |=> !(good_done || bad_done)); // R6
endmodule

// File: rtl/bmdma_ptr_reg.sv
module bmdma_ptr_reg
  import bmdma_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic                  run,
  input  logic [DATA_W-1:PTR_LSB] wr_ptr,
  output logic [DATA_W-1:0]     ptr
);
  logic take;
  assign take = wr && !run;

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (take) ptr <= {wr_ptr, {PTR_LSB{1'b0}}};
  end

  AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && run) |=> $stable(ptr)); // R7
endmodule

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
  import bmdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              dp_done,
  input  logic              dp_error,
  input  logic              dp_irq,
  output logic              run,
  output logic              dir_to_mem,
  output logic [DATA_W-1:0] table_base,
  output logic              host_irq,
  output logic              good_done,
  output logic              bad_done
);
  logic wr_cmd, wr_stat, wr_ptr;
  logic run_rise, run_fall;
  logic active, err, intr;
  logic [1:0] cap;

  assign wr_cmd  = wr_en && (wr_addr == IDX_CMD);
  assign wr_stat = wr_en && (wr_addr == IDX_STAT);
  assign wr_ptr  = wr_en && (wr_addr == IDX_PTR);

  bmdma_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .wr(wr_cmd),
    .wr_run(wr_data[CMD_RUN]), .wr_dir(wr_data[CMD_DIR]),
    .run(run), .dir(dir_to_mem), .run_rise(run_rise), .run_fall(run_fall)
  );

  bmdma_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .wr(wr_stat),
    .w1c_err(wr_data[ST_ERR]), .w1c_int(wr_data[ST_INT]),
    .wr_cap({wr_data[ST_CAP1], wr_data[ST_CAP0]}),
    .run(run), .run_rise(run_rise), .run_fall(run_fall),
    .ev_done(dp_done), .ev_err(dp_error), .ev_irq(dp_irq),
    .active(active), .err(err), .intr(intr), .cap(cap),
    .good_done(good_done), .bad_done(bad_done)
  );

  bmdma_ptr_reg u_ptr (
    .clk(clk), .rst_n(rst_n), .wr(wr_ptr), .run(run),
    .wr_ptr(wr_data[DATA_W-1:PTR_LSB]), .ptr(table_base)
  );

  assign host_irq = intr;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      IDX_CMD: begin
        rd_data[CMD_RUN] = run;
        rd_data[CMD_DIR] = dir_to_mem;
      end
      IDX_STAT: begin
        rd_data[ST_ACT]  = active;
        rd_data[ST_ERR]  = err;
        rd_data[ST_INT]  = intr;
        rd_data[ST_CAP0] = cap[0];
        rd_data[ST_CAP1] = cap[1];
      end
      IDX_PTR: rd_data = table_base;
      default: rd_data = '0;
    endcase
  end

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == IDX_STAT) |-> (rd_data[ST_INT] == host_irq)); // R8
  AST_RUN_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && wr_data[CMD_RUN] && !run) |=> (run && active)); // R3
endmodule

// File: tb/test_bmdma_ctrl.sv
`timescale 1ns/1ps
module test_bmdma_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic dp_done = 1'b0, dp_error = 1'b0, dp_irq = 1'b0;
  logic run, dir_to_mem, host_irq, good_done, bad_done;
  logic [31:0] table_base;

  bmdma_ctrl i_bmdma_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .dp_done(dp_done), .dp_error(dp_error),
    .dp_irq(dp_irq), .run(run), .dir_to_mem(dir_to_mem), .table_base(table_base),
    .host_irq(host_irq), .good_done(good_done), .bad_done(bad_done)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  // bench model state
  logic m_run, m_dir, m_act, m_err, m_int, m_good, m_badd;
  logic [1:0] m_cap;
  logic [31:0] m_ptr;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic graded_good(input logic a, input logic e, input logic i);
    return (a == 1'b0) && (e == 1'b0) && (i == 1'b1);
  endfunction

  function automatic logic [31:0] exp_read(input logic [1:0] idx);
    case (idx)
      2'd0: return {28'd0, m_dir, 2'b00, m_run};
      2'd1: return {25'd0, m_cap, 2'b00, m_int, m_err, m_act};
      2'd2: return m_ptr;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_reset();
    m_run = 0; m_dir = 0; m_act = 0; m_err = 0; m_int = 0;
    m_good = 0; m_badd = 0; m_cap = 0; m_ptr = 0;
  endtask

  task automatic model_step(input logic we, input logic [1:0] a, input logic [31:0] d,
                            input logic dn, input logic er, input logic ir);
    logic wc, ws, rise, fall;
    wc = we && a == 2'd0;
    ws = we && a == 2'd1;
    rise = wc && !m_run && d[0];
    fall = wc && m_run && !d[0];
    m_good = fall && graded_good(m_act, m_err, m_int);
    m_badd = fall && !graded_good(m_act, m_err, m_int);
    if (rise) m_act = 1;
    else if (dn || er || fall) m_act = 0;
    m_err = er || (m_err && !(ws && d[1]));
    m_int = dn || ir || (m_int && !(ws && d[2]));
    if (ws) m_cap = d[6:5];
    if (we && a == 2'd2 && !m_run) m_ptr = d & 32'hFFFF_FFFC;
    if (wc) begin m_run = d[0]; m_dir = d[3]; end
  endtask

  task automatic check_all();
    for (int k = 0; k < 4; k++) begin
      rd_addr = k[1:0];
      #0.2;
      case (k)
        0: chk("R4 command read", rd_data, exp_read(2'd0));
        1: begin
          chk("R3 active bit", {31'd0, rd_data[0]}, {31'd0, m_act});
          chk("R2 error/interrupt bits", {30'd0, rd_data[2:1]}, {30'd0, m_int, m_err});
          chk("R1 capability bits", {30'd0, rd_data[6:5]}, {30'd0, m_cap});
          chk("R2 status other bits", {rd_data[31:7], rd_data[4:3]}, 27'd0);
        end
        2: chk("R7 table base read", rd_data, m_ptr);
        default: chk("R7 index 3 reads zero", rd_data, 32'd0);
      endcase
    end
    chk("R4 run/dir outputs", {30'd0, run, dir_to_mem}, {30'd0, m_run, m_dir});
    chk("R7 table_base port", table_base, m_ptr);
    chk("R8 host_irq", {31'd0, host_irq}, {31'd0, m_int});
    chk("R6 good/bad pulses", {30'd0, good_done, bad_done}, {30'd0, m_good, m_badd});
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [31:0] d,
                      input logic dn, input logic er, input logic ir);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    dp_done = dn; dp_error = er; dp_irq = ir;
    @(posedge clk);
    model_step(we, a, d, dn, er, ir);
    #0.5;
    wr_en = 0; dp_done = 0; dp_error = 0; dp_irq = 0;
    check_all();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(posedge clk);
    #0.5;
    // R9: reset state
    chk("R9 reset outputs", {27'd0, run, dir_to_mem, host_irq, good_done, bad_done}, 32'd0);
    chk("R9 reset table base", table_base, 32'd0);
    @(negedge clk); rst_n = 1;
    check_all();

    // R1: capability bits written and held; W1C with zeros leaves flags
    step(1, 2'd1, 32'h0000_0060, 0, 0, 0);
    step(0, 2'd0, 0, 0, 0, 0);
    step(1, 2'd1, 32'h0000_0020, 0, 0, 0);
    // R7: pointer with low bits set, idle
    step(1, 2'd2, 32'hDEAD_BEEF, 0, 0, 0);
    // R4: direction first, then start with the done event in the same cycle (R3 rise wins)
    step(1, 2'd0, 32'h0000_0008, 0, 0, 0);
    step(1, 2'd0, 32'h0000_0009, 1, 0, 0);
    // R7: pointer write ignored while running
    step(1, 2'd2, 32'h1234_5678, 0, 0, 0);
    // R5: done ends activity and raises interrupt
    step(0, 2'd0, 0, 1, 0, 0);
    // R6: good stop
    step(1, 2'd0, 32'h0000_0008, 0, 0, 0);
    step(0, 2'd0, 0, 0, 0, 0);
    // R2: clear interrupt alone
    step(1, 2'd1, 32'h0000_0024, 0, 0, 0);
    // R6: stop while still active -> bad
    step(1, 2'd0, 32'h0000_0001, 0, 0, 0);
    step(1, 2'd0, 32'h0000_0000, 0, 0, 0);
    // R5: error event, then R2 clear colliding with new error and irq events
    step(0, 2'd0, 0, 0, 1, 0);
    step(1, 2'd1, 32'h0000_0006, 0, 1, 1);
    step(1, 2'd1, 32'h0000_0006, 0, 0, 0);
    // R3: writes to active bit ignored
    step(1, 2'd1, 32'h0000_0001, 0, 0, 0);
    // R5: irq while idle
    step(0, 2'd0, 0, 0, 0, 1);

    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [31:0] d;
      logic [1:0] a;
      d = $urandom();
      a = 2'($urandom_range(0, 3));
      step(($urandom_range(0, 2) != 0), a, d,
           ($urandom_range(0, 7) == 0), ($urandom_range(0, 9) == 0), ($urandom_range(0, 7) == 0));
    end

    finish_run();
  end
endmodule